// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register

This block is a parallel-in, serial-out shift register with a configurable number of stages (eight by default). A word presented on the parallel inputs is captured into all stages whenever the active-low load control is low. While the load control is high, the register advances one stage toward its last stage on each qualified clock edge, and the serial input fills the first stage. The last stage is driven out together with its complement, so a downstream receiver can take either polarity.

The effective shift clock is built from two interchangeable inputs, `clk_a` and `clk_b`. A shift happens when the OR of the two rises. Holding either input high blocks all shifting, so either input can act as a clock inhibit while the other carries the clock. The whole block runs on one free-running system clock. The rising edge of the combined shift clock is detected synchronously, so no gated clock is needed. The load path and both shift-clock inputs are sampled on the system clock edge.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every stage, so that `q_last` reads 0 and `q_last_n` reads 1 after the first system clock edge with `rst` high.
- R2: At a system clock edge with `load_n` low, every stage takes its parallel bit (`par_in[0]` into the first stage, `par_in[WIDTH-1]` into the last). This does not depend on `clk_a`, `clk_b` or `ser_in`.
- R3: A load takes priority over a shift-clock rising edge seen in the same cycle. That edge is consumed and is not applied later.
- R4: With `load_n` high, a rise of (`clk_a` OR `clk_b`) between two system clock edges shifts the register once: `ser_in` enters the first stage and every other stage takes the value of the stage before it.
- R5: While either shift-clock input is held high, toggling the other input causes no shift. The roles of `clk_a` and `clk_b` are interchangeable.
- R6: `q_last_n` is always the logical complement of `q_last`.
- R7: After a load, successive shifts present the parallel bits on `q_last` in the order `par_in[WIDTH-1]`, `par_in[WIDTH-2]`, ... `par_in[0]`. The first-stage bit appears after WIDTH-1 shifts.
- R8: A shift-clock level held high for several cycles produces exactly one shift. Nothing shifts while both shift-clock inputs stay low.
- R9: Raising the inhibit input while the other clock input is low counts as a rising edge and shifts once. This is why the inhibit must only be raised while the clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data entering the first stage on a shift |
| load_n | input | 1 | Active-low parallel load; high enables shifting |
| clk_a | input | 1 | Shift-clock input, interchangeable with clk_b |
| clk_b | input | 1 | Shift-clock input, interchangeable with clk_a |
| par_in | input | WIDTH | Parallel data, bit 0 to first stage |
| q_last | output | 1 | Last stage value |
| q_last_n | output | 1 | Complement of the last stage value |

## Verification
The bench aims at the cycle where a load and a shift-clock rise coincide. A design that queued the edge would shift one place too early after the load is released. It also drives an inhibit input raised while the other input is low, where a design that qualified edges on one input only would miss a shift that a real OR clock makes. Long high levels on either input catch an edge detector that fires on every high level rather than once. A seven-shift walk after a known load exposes a reversed bit order or a wrong stage count.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2
  } psr_act_e;
endpackage

// File: rtl/psr_clk_qual.sv
module psr_clk_qual
  import psr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ck_a,
  input  logic     ck_b,
  input  logic     load_n,
  output psr_act_e act
);
  logic comb_now;
  logic comb_prev;
  logic rise;

  assign comb_now = ck_a | ck_b;
  assign rise     = comb_now & ~comb_prev;

  // Reset treats the combined clock as high so no edge is invented after reset.
  always_ff @(posedge clk) begin
    if (rst) comb_prev <= 1'b1;
    else     comb_prev <= comb_now;
  end

  always_comb begin
    if (!load_n)   act = ACT_LOAD;
    else if (rise) act = ACT_SHIFT;
    else           act = ACT_HOLD;
  end

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SHIFT) |=> (act != ACT_SHIFT));

  // R5
  inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ck_a) || $past(ck_b)) && !$past(rst) |-> (act != ACT_SHIFT));
endmodule

// File: rtl/psr_stage_chain.sv
module psr_stage_chain
  import psr_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  psr_act_e          act,
  input  logic              ser,
  input  logic [STAGES-1:0] par,
  output logic              last_nxt
);
  logic [STAGES-1:0] stages;
  logic [STAGES-1:0] nxt;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic shift_src;
      if (i == 0) begin : g_head
        assign shift_src = ser;
      end else begin : g_body
        assign shift_src = stages[i-1];
      end
      always_comb begin
        case (act)
          ACT_LOAD:  nxt[i] = par[i];
          ACT_SHIFT: nxt[i] = shift_src;
          default:   nxt[i] = stages[i];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= nxt;
  end

  assign last_nxt = rst ? 1'b0 : nxt[STAGES-1];

  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(act) == ACT_LOAD) |-> (stages == $past(par)));

  // R4
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(act) == ACT_SHIFT) |->
      (stages[0] == $past(ser)) && (stages[STAGES-1:1] == $past(stages[STAGES-2:0])));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(act) == ACT_HOLD) |-> $stable(stages));
endmodule

// File: rtl/psr_out_pair.sv
module psr_out_pair (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q,
  output logic q_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      q_n <= 1'b1;
    end else begin
      q   <= d;
      q_n <= ~d;
    end
  end

  // R6
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (q_n == ~q));

  // R1
  reset_value_chk: assert property (@(posedge clk)
    $past(rst) |-> (!q && q_n));
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import psr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             load_n,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_last,
  output logic             q_last_n
);
  psr_act_e act;
  logic     last_nxt;

  psr_clk_qual u_qual (
    .clk    (clk),
    .rst    (rst),
    .ck_a   (clk_a),
    .ck_b   (clk_b),
    .load_n (load_n),
    .act    (act)
  );

  psr_stage_chain #(.STAGES(WIDTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .ser      (ser_in),
    .par      (par_in),
    .last_nxt (last_nxt)
  );

  psr_out_pair u_out (
    .clk (clk),
    .rst (rst),
    .d   (last_nxt),
    .q   (q_last),
    .q_n (q_last_n)
  );

  // R3
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(load_n) |-> (q_last == $past(par_in[WIDTH-1])));
endmodule

// File: tb/tb_piso_shift_reg.sv
module tb_piso_shift_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic         load_n = 1'b1;
  logic         clk_a = 1'b0;
  logic         clk_b = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         q_last;
  logic         q_last_n;

  int n_vec  = 0;
  int n_fail = 0;

  logic [W-1:0] mdl;
  logic         mdl_prev;

  always #2 clk = ~clk;

  piso_shift_reg #(.WIDTH(W)) dut (
    .clk      (clk),
    .rst      (rst),
    .ser_in   (ser_in),
    .load_n   (load_n),
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .par_in   (par_in),
    .q_last   (q_last),
    .q_last_n (q_last_n)
  );

  function automatic logic [W-1:0] next_model(logic [W-1:0] cur, logic prev, logic ld_n,
                                              logic a, logic b, logic s, logic [W-1:0] p);
    if (!ld_n) return p;
    if ((a | b) && !prev) return {cur[W-2:0], s};
    return cur;
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (q_last !== mdl[W-1] || q_last_n !== ~mdl[W-1]) begin
      n_fail++;
      $display("FAIL %s: q=%b q_n=%b expected q=%b q_n=%b", tag, q_last, q_last_n,
               mdl[W-1], ~mdl[W-1]);
    end
  endtask

  task automatic step(string tag, logic ld_n, logic a, logic b, logic s, logic [W-1:0] p);
    @(negedge clk);
    load_n = ld_n; clk_a = a; clk_b = b; ser_in = s; par_in = p;
    mdl      = next_model(mdl, mdl_prev, ld_n, a, b, s, p);
    mdl_prev = a | b;
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1651));
    mdl = '0; mdl_prev = 1'b1;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // R2 load independent of clocks and serial; R7 order H..A
    step("R2 load", 1'b0, 1'b1, 1'b0, 1'b1, 8'hA5);
    step("R2 load clk toggled", 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5);
    for (int k = 0; k < W - 1; k++) begin
      step("R7 walk rise", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      step("R7 walk fall", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    end
    // R5 inhibit on clk_b while clk_a toggles
    step("R2 reload", 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
    step("R5 inhibit up", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R5 inhibit b", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      step("R5 a low under inhibit", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
      step("R5 a high under inhibit", 1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    end
    // R5 roles swapped: clk_a inhibits, clk_b clocks
    step("R5 swap", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    step("R5 swap b high", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    step("R5 swap b low", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    step("R4 b clocks", 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    step("R4 b rise", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    // R8 long high level and long low level
    for (int k = 0; k < 5; k++) step("R8 held high", 1'b1, 1'b0, 1'b1, ~ser_in, 8'h00);
    for (int k = 0; k < 5; k++) step("R8 held low", 1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    // R9 inhibit raised while clock low gives a shift
    step("R9 false edge", 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    step("R9 after", 1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    // R3 edge coinciding with load is consumed
    step("R3 low", 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    step("R3 load plus edge", 1'b0, 1'b1, 1'b0, 1'b1, 8'h81);
    step("R3 released high", 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    step("R3 released again", 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

    // R4 R6 random mix
    for (int k = 0; k < 3000; k++) begin
      logic ld_n;
      ld_n = ($urandom % 8) != 0;
      step("R4 R6 random", ld_n, 1'($urandom), 1'(($urandom % 4) == 0),
           1'($urandom), W'($urandom));
    end

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    mdl = '0; mdl_prev = 1'b1;
    @(posedge clk);
    #1;
    check("R1 reset again");
    @(negedge clk);
    rst = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule